// File: doc/BRIEF.md
# Flag Offset Configuration Loader

This block supplies the two threshold offsets used by a FIFO's programmable flags: the almost-empty offset, counted from the empty boundary, and the almost-full offset, counted from the full boundary. A three-bit configuration select and a parity-format bit are captured only while master reset is held. Together they choose one of three things. The first is a fixed default offset (8, 16, 64, 256 or 1024), which is applied to both thresholds. The second is parallel programming from data-bus words. The third is serial programming over a one-bit input.

In both programming modes the loads follow a fixed order. The almost-empty offset is loaded first and the almost-full offset second. A completion flag rises once the second value is in place, and no further loads are accepted after that. When the parity-format bit selects interspersed parity, bus bit PAR_BIT is treated as a parity position. It is skipped, and the bus bits above it move down by one place to fill the offset. Partial reset leaves the configuration, the loaded values and the position in the load sequence unchanged. While partial reset is held, load strobes are not accepted. The FIFO memory and the flag comparators sit outside this block.

Top module: `ofs_loader`

## Requirements
- R1: Master reset (synchronous, active high) captures `cfg_sel`. The codes 2, 3, 4, 5 and 6 give the default offsets 8, 16, 64, 256 and 1024. The same default goes to both `ae_ofs` and `af_ofs`, and `prog_done` is 1 on the clock edge that ends reset.
- R2: Select code 7 has no mode of its own and falls back to the default offset of 64 on both outputs, with `prog_done` at 1.
- R3: `cfg_sel` and `cfg_par` are sampled only while `rst_mr` is high. Changing them afterwards has no effect on the outputs.
- R4: Select code 1 selects parallel programming. After master reset both offsets read 64 and `prog_done` is 0. The first `ld_wr` cycle loads `ae_ofs`. The second loads `af_ofs` and sets `prog_done`. Each takes effect on the edge where `ld_wr` is sampled high.
- R5: With `cfg_par` at 0 during master reset, a parallel load takes `ld_data[OFS_W-1:0]` as the offset. Bit 8 is then an ordinary offset bit.
- R6: With `cfg_par` at 1 during master reset, a parallel load takes the offset as `{ld_data[OFS_W:9], ld_data[7:0]}`. Bit 8 of `ld_data` is ignored.
- R7: Select code 0 selects serial programming. On each edge with `ser_en` high, one bit of `ser_din` is shifted in, MSB first, and cycles with `ser_en` low shift nothing. After OFS_W bits `ae_ofs` is written. After another OFS_W bits `af_ofs` is written and `prog_done` sets.
- R8: Once `prog_done` is 1, further `ld_wr` or `ser_en` activity leaves both offsets unchanged until the next master reset.
- R9: Partial reset (`rst_pr` high) does not change the offsets, `prog_done` or the load position. Loads presented while it is high are not accepted, and the next load after it is released goes to the register that was next before it.
- R10: Master reset returns the load sequence to the almost-empty register. This holds even if it arrives partway through a sequence.
- R11: In parallel mode `ser_en` has no effect, and in serial mode `ld_wr` has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Write-side clock |
| rst_mr | input | 1 | Master reset, synchronous, active high |
| rst_pr | input | 1 | Partial reset, synchronous, active high |
| cfg_sel | input | 3 | Mode and default select, captured during master reset |
| cfg_par | input | 1 | Interspersed parity format, captured during master reset |
| ld_wr | input | 1 | Parallel offset load strobe |
| ld_data | input | OFS_W+1 | Low data-bus bits used for parallel loads |
| ser_en | input | 1 | Serial shift enable |
| ser_din | input | 1 | Serial offset data, MSB first |
| ae_ofs | output | OFS_W | Almost-empty offset |
| af_ofs | output | OFS_W | Almost-full offset |
| prog_done | output | 1 | Both offsets are final |

## Verification
The bench builds the block with OFS_W = 14 and PAR_BIT = 8. With OFS_W = 14 the largest default of 1024 fits with headroom. Under interspersed parity the top bus bit, ld_data[14], then lands in the offset MSB, so the bit shift above the parity position can be seen at both of its ends. A full serial sequence is only 28 shift cycles at this width, which leaves room to insert idle gaps, a partial reset in the middle of a sequence, and a master reset in the middle of a sequence.

// File: rtl/ofsld_pkg.sv
package ofsld_pkg;

    typedef enum logic [1:0] {
        MODE_DEF = 2'd0,
        MODE_PAR = 2'd1,
        MODE_SER = 2'd2
    } mode_e;

    typedef enum logic {
        STEP_AE = 1'b0,
        STEP_AF = 1'b1
    } step_e;

    localparam logic [2:0] SEL_SER = 3'd0;
    localparam logic [2:0] SEL_PAR = 3'd1;

endpackage

// File: rtl/ofsld_sel_decode.sv
module ofsld_sel_decode
    import ofsld_pkg::*;
#(
    parameter int OFS_W = 14
) (
    input  logic [2:0]       sel,
    output mode_e            mode,
    output logic [OFS_W-1:0] dflt
);
    localparam logic [OFS_W-1:0] ONE = {{(OFS_W-1){1'b0}}, 1'b1};

    logic [3:0] pow;

    always_comb begin
        case (sel)
            3'd2:    pow = 4'd3;
            3'd3:    pow = 4'd4;
            3'd4:    pow = 4'd6;
            3'd5:    pow = 4'd8;
            3'd6:    pow = 4'd10;
            default: pow = 4'd6;
        endcase
        if (sel == SEL_SER) begin
            mode = MODE_SER;
        end else if (sel == SEL_PAR) begin
            mode = MODE_PAR;
        end else begin
            mode = MODE_DEF;
        end
        dflt = ONE << pow;
    end

endmodule

// File: rtl/ofsld_par_extract.sv
module ofsld_par_extract #(
    parameter int OFS_W   = 14,
    parameter int PAR_BIT = 8
) (
    input  logic [OFS_W:0]   bus,
    input  logic             par_fmt,
    output logic [OFS_W-1:0] value
);
    logic [OFS_W-1:0] plain;
    logic [OFS_W-1:0] skipped;

    assign plain = bus[OFS_W-1:0];

    for (genvar i = 0; i < OFS_W; i++) begin : g_bit
        if (i < PAR_BIT) begin : g_low
            assign skipped[i] = bus[i];
        end else begin : g_high
            assign skipped[i] = bus[i+1];
        end
    end

    assign value = par_fmt ? skipped : plain;

endmodule

// File: rtl/ofsld_serial_shift.sv
module ofsld_serial_shift #(
    parameter int OFS_W = 14
) (
    input  logic             clk,
    input  logic             clr,
    input  logic             en,
    input  logic             din,
    output logic [OFS_W-1:0] word,
    output logic             word_vld
);
    localparam int CNT_W = $clog2(OFS_W);
    localparam logic [CNT_W-1:0] LAST = CNT_W'(OFS_W - 1);

    typedef struct packed {
        logic [OFS_W-2:0] sr;
        logic [CNT_W-1:0] cnt;
    } shf_t;

    shf_t shf_d, shf_q;

    always_comb begin
        shf_d    = shf_q;
        word_vld = 1'b0;
        word     = {shf_q.sr, din};
        if (clr) begin
            shf_d = '0;
        end else if (en) begin
            if (shf_q.cnt == LAST) begin
                word_vld  = 1'b1;
                shf_d.cnt = '0;
                shf_d.sr  = '0;
            end else begin
                shf_d.cnt = shf_q.cnt + 1'b1;
                shf_d.sr  = {shf_q.sr[OFS_W-3:0], din};
            end
        end
    end

    always_ff @(posedge clk) begin
        shf_q <= shf_d;
    end

endmodule

// File: rtl/ofs_loader.sv
module ofs_loader
    import ofsld_pkg::*;
#(
    parameter int OFS_W   = 14,
    parameter int PAR_BIT = 8
) (
    input  logic             clk,
    input  logic             rst_mr,
    input  logic             rst_pr,
    input  logic [2:0]       cfg_sel,
    input  logic             cfg_par,
    input  logic             ld_wr,
    input  logic [OFS_W:0]   ld_data,
    input  logic             ser_en,
    input  logic             ser_din,
    output logic [OFS_W-1:0] ae_ofs,
    output logic [OFS_W-1:0] af_ofs,
    output logic             prog_done
);

    typedef struct packed {
        mode_e            mode;
        logic             par;
        logic [OFS_W-1:0] ae;
        logic [OFS_W-1:0] af;
        step_e            step;
        logic             done;
    } cfg_t;

    cfg_t cfg_d, cfg_q;

    mode_e            dec_mode;
    logic [OFS_W-1:0] dec_dflt;
    logic [OFS_W-1:0] par_val;
    logic [OFS_W-1:0] ser_word;
    logic             ser_vld;
    logic             ser_go;
    logic             ld_vld;
    logic [OFS_W-1:0] ld_val;

    ofsld_sel_decode #(.OFS_W(OFS_W)) u_dec (
        .sel  (cfg_sel),
        .mode (dec_mode),
        .dflt (dec_dflt)
    );

    ofsld_par_extract #(.OFS_W(OFS_W), .PAR_BIT(PAR_BIT)) u_par (
        .bus     (ld_data),
        .par_fmt (cfg_q.par),
        .value   (par_val)
    );

    assign ser_go = ser_en && !rst_pr && !cfg_q.done && (cfg_q.mode == MODE_SER);

    ofsld_serial_shift #(.OFS_W(OFS_W)) u_ser (
        .clk      (clk),
        .clr      (rst_mr),
        .en       (ser_go),
        .din      (ser_din),
        .word     (ser_word),
        .word_vld (ser_vld)
    );

    always_comb begin
        cfg_d  = cfg_q;
        ld_vld = 1'b0;
        ld_val = par_val;
        if (rst_mr) begin
            cfg_d.mode = dec_mode;
            cfg_d.par  = cfg_par;
            cfg_d.ae   = dec_dflt;
            cfg_d.af   = dec_dflt;
            cfg_d.step = STEP_AE;
            cfg_d.done = (dec_mode == MODE_DEF);
        end else if (!cfg_q.done && !rst_pr) begin
            if (cfg_q.mode == MODE_PAR) begin
                ld_vld = ld_wr;
                ld_val = par_val;
            end else if (cfg_q.mode == MODE_SER) begin
                ld_vld = ser_vld;
                ld_val = ser_word;
            end
            if (ld_vld) begin
                if (cfg_q.step == STEP_AE) begin
                    cfg_d.ae   = ld_val;
                    cfg_d.step = STEP_AF;
                end else begin
                    cfg_d.af   = ld_val;
                    cfg_d.done = 1'b1;
                end
            end
        end
    end

    always_ff @(posedge clk) begin
        cfg_q <= cfg_d;
    end

    assign ae_ofs    = cfg_q.ae;
    assign af_ofs    = cfg_q.af;
    assign prog_done = cfg_q.done;

endmodule

// File: rtl/ofs_loader_chk.sv
module ofs_loader_chk #(
    parameter int OFS_W = 14
) (
    input logic             clk,
    input logic             rst_mr,
    input logic             rst_pr,
    input logic [2:0]       cfg_sel,
    input logic [OFS_W-1:0] ae_ofs,
    input logic [OFS_W-1:0] af_ofs,
    input logic             prog_done
);

    // R1 and R2: default codes finish immediately, programming codes do not (R4, R7)
    p_mr_done_r1: assert property (@(posedge clk) disable iff (rst_mr)
        $past(rst_mr) |-> (prog_done == ($past(cfg_sel) > 3'd1)));

    // R2: a default is a single power of two, shared by both offsets
    p_default_pow2_r2: assert property (@(posedge clk) disable iff (rst_mr)
        ($past(rst_mr) && ($past(cfg_sel) > 3'd1)) |-> (($countones(ae_ofs) == 1) && (ae_ofs == af_ofs)));

    // R4: programming modes start with 64 in both offsets
    p_prog_start_r4: assert property (@(posedge clk) disable iff (rst_mr)
        ($past(rst_mr) && ($past(cfg_sel) < 3'd2)) |-> ((ae_ofs == OFS_W'(64)) && (af_ofs == OFS_W'(64))));

    // R8: the completion flag and the offsets are frozen once it is set
    p_done_hold_r8: assert property (@(posedge clk) disable iff (rst_mr)
        prog_done |=> (prog_done && $stable(ae_ofs) && $stable(af_ofs)));

    // R9: partial reset disturbs nothing
    p_pr_hold_r9: assert property (@(posedge clk) disable iff (rst_mr)
        rst_pr |=> ($stable(ae_ofs) && $stable(af_ofs) && $stable(prog_done)));

endmodule

bind ofs_loader ofs_loader_chk #(.OFS_W(OFS_W)) u_chk (
    .clk       (clk),
    .rst_mr    (rst_mr),
    .rst_pr    (rst_pr),
    .cfg_sel   (cfg_sel),
    .ae_ofs    (ae_ofs),
    .af_ofs    (af_ofs),
    .prog_done (prog_done)
);

// File: tb/tb_ofs_loader.sv
module tb_ofs_loader;

    localparam int OFS_W   = 14;
    localparam int PAR_BIT = 8;

    logic             clk = 1'b0;
    logic             rst_mr = 1'b1;
    logic             rst_pr = 1'b0;
    logic [2:0]       cfg_sel = 3'd4;
    logic             cfg_par = 1'b0;
    logic             ld_wr = 1'b0;
    logic [OFS_W:0]   ld_data = '0;
    logic             ser_en = 1'b0;
    logic             ser_din = 1'b0;
    logic [OFS_W-1:0] ae_ofs;
    logic [OFS_W-1:0] af_ofs;
    logic             prog_done;

    int n_cmp = 0;
    int n_bad = 0;

    always #10 clk = ~clk;

    ofs_loader #(.OFS_W(OFS_W), .PAR_BIT(PAR_BIT)) dut (
        .clk       (clk),
        .rst_mr    (rst_mr),
        .rst_pr    (rst_pr),
        .cfg_sel   (cfg_sel),
        .cfg_par   (cfg_par),
        .ld_wr     (ld_wr),
        .ld_data   (ld_data),
        .ser_en    (ser_en),
        .ser_din   (ser_din),
        .ae_ofs    (ae_ofs),
        .af_ofs    (af_ofs),
        .prog_done (prog_done)
    );

    // sel code, expected default
    localparam logic [16:0] DEF_TAB [0:5] = '{
        {3'd2, 14'd8},
        {3'd3, 14'd16},
        {3'd4, 14'd64},
        {3'd5, 14'd256},
        {3'd6, 14'd1024},
        {3'd7, 14'd64}
    };

    function automatic logic [13:0] exp_par(input logic [14:0] d, input logic p);
        if (!p) return d[13:0];
        return {d[14:9], d[7:0]};
    endfunction

    task automatic check(input string req, input int act, input int exp);
        n_cmp++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic master_reset(input logic [2:0] s, input logic p);
        rst_mr  = 1'b1;
        cfg_sel = s;
        cfg_par = p;
        @(negedge clk);
        rst_mr  = 1'b0;
        cfg_sel = ~s;
        cfg_par = ~p;
    endtask

    task automatic pword(input logic [14:0] d);
        ld_wr   = 1'b1;
        ld_data = d;
        @(negedge clk);
        ld_wr   = 1'b0;
        ld_data = '0;
    endtask

    task automatic sbit(input logic b);
        ser_en  = 1'b1;
        ser_din = b;
        @(negedge clk);
        ser_en  = 1'b0;
    endtask

    task automatic sword(input logic [13:0] v, input bit gap);
        for (int i = 13; i >= 0; i--) begin
            sbit(v[i]);
            if (gap && i == 7) begin
                ser_din = 1'b1;
                @(negedge clk);
                @(negedge clk);
            end
        end
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog: actual hung expected finish");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        @(negedge clk);
        @(negedge clk);

        // R1, R2: table of default codes
        for (int k = 0; k < 6; k++) begin
            master_reset(DEF_TAB[k][16:14], 1'b0);
            check(k == 5 ? "R2 ae" : "R1 ae", int'(ae_ofs), int'(DEF_TAB[k][13:0]));
            check(k == 5 ? "R2 af" : "R1 af", int'(af_ofs), int'(DEF_TAB[k][13:0]));
            check(k == 5 ? "R2 done" : "R1 done", int'(prog_done), 1);
        end

        // R3: select changes after reset are ignored
        master_reset(3'd2, 1'b0);
        cfg_sel = 3'd6;
        repeat (4) @(negedge clk);
        check("R3 ae", int'(ae_ofs), 8);
        cfg_sel = 3'd1;
        pword(15'h1234);
        check("R3 no load", int'(ae_ofs), 8);

        // R4, R5, R11: parallel, no parity
        master_reset(3'd1, 1'b0);
        check("R4 start ae", int'(ae_ofs), 64);
        check("R4 start done", int'(prog_done), 0);
        for (int i = 0; i < 20; i++) sbit(1'b1);
        check("R11 ser ignored in par", int'(ae_ofs), 64);
        check("R11 ser ignored done", int'(prog_done), 0);
        pword(15'h5B5A);
        check("R5 ae", int'(ae_ofs), int'(exp_par(15'h5B5A, 1'b0)));
        check("R4 af untouched", int'(af_ofs), 64);
        check("R4 mid done", int'(prog_done), 0);
        // R9: partial reset blocks load and keeps position
        rst_pr = 1'b1;
        pword(15'h0FFF);
        rst_pr = 1'b0;
        check("R9 af held", int'(af_ofs), 64);
        check("R9 ae held", int'(ae_ofs), int'(exp_par(15'h5B5A, 1'b0)));
        check("R9 done held", int'(prog_done), 0);
        pword(15'h0133);
        check("R4 af", int'(af_ofs), int'(exp_par(15'h0133, 1'b0)));
        check("R4 done", int'(prog_done), 1);
        check("R9 ae after pr", int'(ae_ofs), int'(exp_par(15'h5B5A, 1'b0)));
        // R8: loads after completion ignored
        pword(15'h7FFF);
        pword(15'h7FFF);
        check("R8 ae", int'(ae_ofs), int'(exp_par(15'h5B5A, 1'b0)));
        check("R8 af", int'(af_ofs), int'(exp_par(15'h0133, 1'b0)));

        // R6: interspersed parity
        master_reset(3'd1, 1'b1);
        pword(15'h4312);
        check("R6 ae", int'(ae_ofs), int'(exp_par(15'h4312, 1'b1)));
        pword(15'h0100);
        check("R6 bit8 ignored", int'(af_ofs), 0);
        check("R6 done", int'(prog_done), 1);
        master_reset(3'd1, 1'b1);
        pword(15'h7FFF);
        check("R6 top bit", int'(ae_ofs), 16'h3FFF);

        // R7, R11: serial with gaps
        master_reset(3'd0, 1'b0);
        check("R7 start done", int'(prog_done), 0);
        sword(14'h2ABC, 1'b1);
        check("R7 ae", int'(ae_ofs), 16'h2ABC);
        check("R7 mid done", int'(prog_done), 0);
        pword(15'h1111);
        check("R11 wr ignored in ser", int'(af_ofs), 64);
        sword(14'h0155, 1'b0);
        check("R7 af", int'(af_ofs), 16'h0155);
        check("R7 done", int'(prog_done), 1);
        sword(14'h3FFF, 1'b0);
        check("R8 ser after done", int'(af_ofs), 16'h0155);

        // R10: master reset mid-sequence restarts at almost-empty
        master_reset(3'd0, 1'b0);
        sword(14'h0AAA, 1'b0);
        for (int i = 0; i < 5; i++) sbit(1'b1);
        master_reset(3'd0, 1'b0);
        check("R10 ae reset", int'(ae_ofs), 64);
        sword(14'h1234, 1'b0);
        check("R10 ae reload", int'(ae_ofs), 16'h1234);
        check("R10 af", int'(af_ofs), 64);
        check("R10 done", int'(prog_done), 0);

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

endmodule